// File: doc/BRIEF.md
# Calendar time-of-day counter

This block is the counting core of a real-time clock. It holds hundredths of a second, seconds, minutes, hours, day of month, month, year and day of week as plain binary byte fields. A single-cycle pulse on `tick_i` arrives one hundred times a second from an external prescaler. While the run control is set, each pulse moves the time forward by one hundredth and ripples carries up through the calendar. Day rollover follows the length of the month, with a leap-year February.

Software reaches the block through a 32-entry byte register space. It uses a write strobe with an address and data, and a read port that returns the addressed byte in the same cycle. Eight time fields and eight compare bytes of matching layout are readable and writable. A write-only command byte sets run/stop, the 12- or 24-hour hour format and a two-bit input-frequency code, and these appear on plain control outputs. The register port is a plain strobe interface with no back-pressure: every write is accepted in the cycle it is presented, and reads never stall.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the command state is cleared (`run_o`=0, `fmt24_o`=0, `freq_sel_o`=0). The time fields read hundredths 0, hour 12, minute 0, second 0, month 1, day 1, year 0 and weekday 0. All compare bytes read 0.
- R2: Time fields sit at fixed addresses: 0 hundredths, 1 hour, 2 minute, 3 second, 4 month, 5 day, 6 year (0 means 1968), 7 weekday. A write stores the byte and a read at the same address returns it.
- R3: Addresses 8 to 15 are compare bytes laid out like addresses 0 to 7. They hold whatever was written and are never changed by ticks.
- R4: A read of address 17 (command), 16 or any of 18 to 31 returns 0xFF. A write to 16 or 18 to 31 changes no readable byte and no control output.
- R5: A write to address 17 sets `run_o` from bit 3, `fmt24_o` from bit 2 and `freq_sel_o` from bits 1:0. Its other bits have no effect.
- R6: While `run_o` is 0, ticks leave every time field unchanged.
- R7: While running, each tick adds one to hundredths. Hundredths 99 wraps to 0 and carries into seconds, seconds 59 wraps to 0 and carries into minutes, and minutes 59 wraps to 0 and carries into hours.
- R8: In 24-hour format the hour runs 0 to 23, and a carry out of 23 gives 0 and carries into the day.
- R9: In 12-hour format the hour holds 1 to 12 in bits 6:0, with bit 7 set for PM. A carry out of 11 gives 12 and flips bit 7. A carry out of 12 gives 1 with bit 7 kept. A carry out of 11 PM (0x8B) gives 0x0C and carries into the day.
- R10: A day carry past the last day of the month gives day 1 and carries into the month. April, June, September and November have 30 days, February 29 when (year+1968) is divisible by 4 and 28 otherwise, and the rest 31.
- R11: A day carry also steps the weekday, with 6 wrapping to 0. A carry out of month 12 gives month 1 and adds one to the year, and year 255 wraps to 0.
- R12: When a time-field write and an advancing tick fall in the same cycle, the written field takes the written byte. Every other field takes its ticked value, with carries computed from the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, 100 per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, same cycle |
| run_o | output | 1 | Counting enabled |
| fmt24_o | output | 1 | 1 = 24-hour hour format, 0 = 12-hour |
| freq_sel_o | output | 2 | Input-frequency code from the command byte |

## Verification
A software write to a time field and an advancing tick can land in the same clock cycle. The interesting case is a tick that would carry into the field being written. The bench sets hundredths to 99 and seconds to 59, then raises the tick together with a seconds write. It judges the result by reading back the seconds (which must hold the written byte), the hundredths (which must be 0) and the minutes (which must still have taken the carry from the old seconds). Random runs also pair writes with ticks, and their readbacks are compared against a bench model that applies the same ordering.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 8;
  localparam int IDX_W      = $clog2(NUM_FIELDS);

  // field positions inside a time bank; the address map depends on this order
  localparam int IDX_HUND = 0;
  localparam int IDX_HOUR = 1;
  localparam int IDX_MIN  = 2;
  localparam int IDX_SEC  = 3;
  localparam int IDX_MON  = 4;
  localparam int IDX_DAY  = 5;
  localparam int IDX_YEAR = 6;
  localparam int IDX_DOW  = 7;

  typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_bank_t;

  // command byte bit positions
  localparam int CMD_RUN_BIT  = 3;
  localparam int CMD_FMT_BIT  = 2;
  localparam int CMD_FREQ_LSB = 0;
  localparam int CMD_FREQ_W   = 2;
endpackage

// File: rtl/rtc_cmd_reg.sv
module rtc_cmd_reg #(
  parameter int ADDR_W   = 5,
  parameter int CMD_ADDR = 17
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [rtc_pkg::FIELD_W-1:0]      wdata_i,
  output logic                             run_o,
  output logic                             fmt24_o,
  output logic [rtc_pkg::CMD_FREQ_W-1:0]   freq_o
);
  import rtc_pkg::*;
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CMD_ADDR);

  logic hit;
  assign hit = wr_en_i && (addr_i == HIT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o   <= 1'b0;
      fmt24_o <= 1'b0;
      freq_o  <= '0;
    end else if (hit) begin
      run_o   <= wdata_i[CMD_RUN_BIT];
      fmt24_o <= wdata_i[CMD_FMT_BIT];
      freq_o  <= wdata_i[CMD_FREQ_LSB +: CMD_FREQ_W];
    end
  end
endmodule

// File: rtl/rtc_cmp_bank.sv
module rtc_cmp_bank #(
  parameter int NUM = rtc_pkg::NUM_FIELDS,
  parameter int W   = rtc_pkg::FIELD_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  logic [$clog2(NUM)-1:0]       idx_i,
  input  logic [W-1:0]                 wdata_i,
  output logic [NUM-1:0][W-1:0]        cmp_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cmp_o[g] <= '0;
      else if (wr_en_i && (idx_i == g[$clog2(NUM)-1:0]))
        cmp_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
  input  logic [rtc_pkg::FIELD_W-1:0] hour_i,
  input  logic                        fmt24_i,
  output logic [rtc_pkg::FIELD_W-1:0] hour_o,
  output logic                        day_carry_o
);
  localparam logic [7:0] H24_LAST = 8'd23;
  localparam logic [6:0] H12_ELEV = 7'd11;
  localparam logic [6:0] H12_TOP  = 7'd12;

  logic       pm;
  logic [6:0] h12;
  assign pm  = hour_i[7];
  assign h12 = hour_i[6:0];

  always_comb begin
    hour_o      = hour_i;
    day_carry_o = 1'b0;
    if (fmt24_i) begin
      if (hour_i >= H24_LAST) begin
        hour_o      = '0;
        day_carry_o = 1'b1;
      end else begin
        hour_o = hour_i + 8'd1;
      end
    end else begin
      if (h12 == H12_ELEV) begin
        hour_o      = {~pm, H12_TOP};
        day_carry_o = pm;          // 11 PM rolls to 12 AM: new day
      end else if (h12 >= H12_TOP) begin
        hour_o = {pm, 7'd1};
      end else begin
        hour_o = {pm, h12 + 7'd1};
      end
    end
  end
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
  parameter int YEAR_BASE = 1968
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tick_i,
  input  logic                              run_i,
  input  logic                              fmt24_i,
  input  logic                              wr_en_i,
  input  logic [rtc_pkg::IDX_W-1:0]         idx_i,
  input  logic [rtc_pkg::FIELD_W-1:0]       wdata_i,
  output rtc_pkg::field_bank_t              tm_o
);
  import rtc_pkg::*;

  localparam logic [1:0] BASE_MOD  = 2'(YEAR_BASE % 4);
  localparam logic [7:0] HUND_LAST = 8'd99;
  localparam logic [7:0] MS_LAST   = 8'd59;
  localparam logic [7:0] MON_LAST  = 8'd12;
  localparam logic [7:0] DOW_LAST  = 8'd6;

  field_bank_t tm_q, tm_d;
  logic        c_sec, c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0]  hour_nx;
  logic        hour_carry;
  logic [7:0]  dim;

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic leap;
    leap = ((yr[1:0] + BASE_MOD) == 2'b00);
    case (mon)
      8'd4, 8'd6, 8'd9, 8'd11: month_len = 8'd30;
      8'd2:                    month_len = leap ? 8'd29 : 8'd28;
      default:                 month_len = 8'd31;
    endcase
  endfunction

  rtc_hour_step u_hour (
    .hour_i      (tm_q[IDX_HOUR]),
    .fmt24_i     (fmt24_i),
    .hour_o      (hour_nx),
    .day_carry_o (hour_carry)
  );

  assign dim = month_len(tm_q[IDX_MON], tm_q[IDX_YEAR]);

  always_comb begin
    tm_d  = tm_q;
    c_sec = 1'b0;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;
    if (tick_i && run_i) begin
      c_sec          = tm_q[IDX_HUND] >= HUND_LAST;
      tm_d[IDX_HUND] = c_sec ? 8'd0 : tm_q[IDX_HUND] + 8'd1;
    end
    if (c_sec) begin
      c_min         = tm_q[IDX_SEC] >= MS_LAST;
      tm_d[IDX_SEC] = c_min ? 8'd0 : tm_q[IDX_SEC] + 8'd1;
    end
    if (c_min) begin
      c_hr          = tm_q[IDX_MIN] >= MS_LAST;
      tm_d[IDX_MIN] = c_hr ? 8'd0 : tm_q[IDX_MIN] + 8'd1;
    end
    if (c_hr) begin
      tm_d[IDX_HOUR] = hour_nx;
      c_day          = hour_carry;
    end
    if (c_day) begin
      tm_d[IDX_DOW] = (tm_q[IDX_DOW] >= DOW_LAST) ? 8'd0 : tm_q[IDX_DOW] + 8'd1;
      c_mon         = tm_q[IDX_DAY] >= dim;
      tm_d[IDX_DAY] = c_mon ? 8'd1 : tm_q[IDX_DAY] + 8'd1;
    end
    if (c_mon) begin
      c_yr          = tm_q[IDX_MON] >= MON_LAST;
      tm_d[IDX_MON] = c_yr ? 8'd1 : tm_q[IDX_MON] + 8'd1;
    end
    if (c_yr)
      tm_d[IDX_YEAR] = tm_q[IDX_YEAR] + 8'd1;
    // software write overrides only the field it addresses
    if (wr_en_i)
      tm_d[idx_i] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_q           <= '0;
      tm_q[IDX_HOUR] <= 8'd12;
      tm_q[IDX_MON]  <= 8'd1;
      tm_q[IDX_DAY]  <= 8'd1;
    end else begin
      tm_q <= tm_d;
    end
  end

  assign tm_o = tm_q;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int ADDR_W    = 5,
  parameter int CMD_ADDR  = 17,
  parameter int YEAR_BASE = 1968
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              run_o,
  output logic              fmt24_o,
  output logic [1:0]        freq_sel_o
);
  import rtc_pkg::*;

  localparam logic [ADDR_W-1:0] CMP_BASE = ADDR_W'(NUM_FIELDS);
  localparam logic [ADDR_W-1:0] CMP_END  = ADDR_W'(2 * NUM_FIELDS);
  localparam logic [7:0]        UNDEF_RD = 8'hFF;

  field_bank_t                            tm_q;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0]     cmp_q;
  logic                                   in_time, in_cmp;
  logic [IDX_W-1:0]                       idx;

  assign in_time = addr_i < CMP_BASE;
  assign in_cmp  = (addr_i >= CMP_BASE) && (addr_i < CMP_END);
  assign idx     = addr_i[IDX_W-1:0];

  rtc_cmd_reg #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .run_o   (run_o),
    .fmt24_o (fmt24_o),
    .freq_o  (freq_sel_o)
  );

  rtc_time_counter #(.YEAR_BASE(YEAR_BASE)) u_time (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .run_i   (run_o),
    .fmt24_i (fmt24_o),
    .wr_en_i (wr_en_i && in_time),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .tm_o    (tm_q)
  );

  rtc_cmp_bank #(.NUM(NUM_FIELDS), .W(FIELD_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i && in_cmp),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .cmp_o   (cmp_q)
  );

  always_comb begin
    if (in_time)     rdata_o = tm_q[idx];
    else if (in_cmp) rdata_o = cmp_q[idx];
    else             rdata_o = UNDEF_RD;
  end
endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_i,
  input logic                 wr_en_i,
  input logic [4:0]           addr_i,
  input logic [7:0]           wdata_i,
  input logic [7:0]           rdata_o,
  input logic                 run_o,
  input logic                 fmt24_o,
  input rtc_pkg::field_bank_t tm
);
  assert_cmd_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!run_o && !fmt24_o));

  assert_undef_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i >= 5'd16) |-> (rdata_o == 8'hFF));

  assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !wr_en_i) |=> $stable(tm));

  assert_hund_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && tick_i && !wr_en_i && tm[0] < 8'd99) |=> (tm[0] == $past(tm[0]) + 8'd1));

  assert_hund_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && tick_i && !wr_en_i && tm[0] == 8'd99) |=> (tm[0] == 8'd0));

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i < 5'd8) |=> (tm[$past(addr_i[2:0])] == $past(wdata_i)));
endmodule

bind rtc_calendar_core rtc_calendar_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_i  (tick_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .run_o   (run_o),
  .fmt24_o (fmt24_o),
  .tm      (tm_q)
);

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       run_o, fmt24_o;
  logic [1:0] freq_sel_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] m [8];
  logic [7:0] cm [8];
  bit         m_run, m_f24;
  logic [1:0] m_freq;

  always #5 clk = ~clk;

  rtc_calendar_core dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .run_o(run_o), .fmt24_o(fmt24_o), .freq_sel_o(freq_sel_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_dim(logic [7:0] mo, logic [7:0] yr);
    bit leap;
    leap = ((int'(yr) + 1968) % 4) == 0;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 8'd30;
    if (mo == 2) return leap ? 8'd29 : 8'd28;
    return 8'd31;
  endfunction

  // reference model of one clock edge, built from R5..R12
  task automatic model_step(bit tk, bit we, logic [4:0] a, logic [7:0] d);
    logic [7:0] n [8];
    bit cs, cmn, ch, cd, cmo, cy;
    for (int i = 0; i < 8; i++) n[i] = m[i];
    cs = 0; cmn = 0; ch = 0; cd = 0; cmo = 0; cy = 0;
    if (tk && m_run) begin
      cs = m[0] >= 99; n[0] = cs ? 8'd0 : m[0] + 8'd1;
      if (cs) begin cmn = m[3] >= 59; n[3] = cmn ? 8'd0 : m[3] + 8'd1; end
      if (cmn) begin ch = m[2] >= 59; n[2] = ch ? 8'd0 : m[2] + 8'd1; end
      if (ch) begin
        if (m_f24) begin
          cd = m[1] >= 23; n[1] = cd ? 8'd0 : m[1] + 8'd1;
        end else if (m[1][6:0] == 7'd11) begin
          n[1] = {~m[1][7], 7'd12}; cd = m[1][7];
        end else if (m[1][6:0] >= 7'd12) begin
          n[1] = {m[1][7], 7'd1};
        end else begin
          n[1] = {m[1][7], m[1][6:0] + 7'd1};
        end
      end
      if (cd) begin
        n[7] = (m[7] >= 6) ? 8'd0 : m[7] + 8'd1;
        cmo = m[5] >= exp_dim(m[4], m[6]); n[5] = cmo ? 8'd1 : m[5] + 8'd1;
      end
      if (cmo) begin cy = m[4] >= 12; n[4] = cy ? 8'd1 : m[4] + 8'd1; end
      if (cy) n[6] = m[6] + 8'd1;
    end
    if (we) begin
      if (a < 8) n[a[2:0]] = d;
      else if (a < 16) cm[a[2:0]] = d;
      else if (a == 17) begin m_run = d[3]; m_f24 = d[2]; m_freq = d[1:0]; end
    end
    for (int i = 0; i < 8; i++) m[i] = n[i];
  endtask

  task automatic cyc(bit tk, bit we, logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    tick_i = tk; wr_en_i = we; addr_i = a; wdata_i = d;
    @(posedge clk);
    model_step(tk, we, a, d);
    #1;
    tick_i = 0; wr_en_i = 0;
  endtask

  task automatic rd_chk(logic [4:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    addr_i = a;
    #1;
    chk(rdata_o == exp, req, rdata_o, exp);
  endtask

  task automatic chk_time(string req);
    for (int i = 0; i < 8; i++) rd_chk(5'(i), m[i], req);
  endtask

  task automatic chk_ctrl(string req);
    @(negedge clk);
    chk({run_o, fmt24_o, freq_sel_o} == {m_run, m_f24, m_freq}, req,
        {run_o, fmt24_o, freq_sel_o}, {m_run, m_f24, m_freq});
  endtask

  task automatic set_time(logic [7:0] hu, hr, mi, se, mo, dy, yr, dw);
    cyc(0, 1, 5'd0, hu); cyc(0, 1, 5'd1, hr); cyc(0, 1, 5'd2, mi); cyc(0, 1, 5'd3, se);
    cyc(0, 1, 5'd4, mo); cyc(0, 1, 5'd5, dy); cyc(0, 1, 5'd6, yr); cyc(0, 1, 5'd7, dw);
  endtask

  function automatic logic [7:0] rand_field(int f);
    case (f)
      0: return 8'($urandom % 100);
      1: return m_f24 ? 8'($urandom % 24) : {1'($urandom), 7'(1 + $urandom % 12)};
      2, 3: return 8'($urandom % 60);
      4: return 8'(1 + $urandom % 12);
      5: return 8'(1 + $urandom % 28);
      6: return 8'($urandom);
      default: return 8'($urandom % 7);
    endcase
  endfunction

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m[0] = 0; m[1] = 12; m[2] = 0; m[3] = 0; m[4] = 1; m[5] = 1; m[6] = 0; m[7] = 0;
    for (int i = 0; i < 8; i++) cm[i] = 0;
    m_run = 0; m_f24 = 0; m_freq = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk_ctrl("R1");
    chk_time("R1");
    for (int i = 8; i < 16; i++) rd_chk(5'(i), 8'h00, "R1");

    // R5 command bits; R4 command reads back 0xFF
    cyc(0, 1, 5'd17, 8'hF2); chk_ctrl("R5");
    rd_chk(5'd17, 8'hFF, "R4");
    cyc(0, 1, 5'd17, 8'h0D); chk_ctrl("R5");

    // R2 map, R6 stopped ticks ignored
    cyc(0, 1, 5'd17, 8'h04);
    set_time(8'd42, 8'd7, 8'd13, 8'd21, 8'd6, 8'd9, 8'd50, 8'd3);
    chk_time("R2");
    repeat (5) cyc(1, 0, 0, 0);
    chk_time("R6");

    // R3 compare bytes unaffected by ticks
    for (int i = 8; i < 16; i++) cyc(0, 1, 5'(i), 8'(8'hA0 + i));
    cyc(0, 1, 5'd17, 8'h0C);
    repeat (3) cyc(1, 0, 0, 0);
    for (int i = 8; i < 16; i++) rd_chk(5'(i), cm[i-8], "R3");
    chk_time("R7");

    // R4 undefined writes ignored, reads 0xFF
    cyc(0, 1, 5'd16, 8'h00); cyc(0, 1, 5'd20, 8'h00); cyc(0, 1, 5'd31, 8'h00);
    rd_chk(5'd16, 8'hFF, "R4"); rd_chk(5'd25, 8'hFF, "R4"); rd_chk(5'd31, 8'hFF, "R4");
    chk_ctrl("R4"); chk_time("R4");

    // R8/R10/R11 year-end rollover in 24h mode, into leap year 1972
    set_time(8'd99, 8'd23, 8'd59, 8'd59, 8'd12, 8'd31, 8'd3, 8'd6);
    cyc(1, 0, 0, 0); chk_time("R11");
    chk((m[6] == 4) && (m[7] == 0) && (m[1] == 0), "R8", m[6], 4);
    // R10 leap February
    set_time(8'd99, 8'd23, 8'd59, 8'd59, 8'd2, 8'd28, 8'd4, 8'd1);
    cyc(1, 0, 0, 0); rd_chk(5'd5, 8'd29, "R10"); rd_chk(5'd4, 8'd2, "R10");
    cyc(0, 1, 5'd0, 8'd99); cyc(0, 1, 5'd3, 8'd59); cyc(0, 1, 5'd2, 8'd59); cyc(0, 1, 5'd1, 8'd23);
    cyc(1, 0, 0, 0); rd_chk(5'd5, 8'd1, "R10"); rd_chk(5'd4, 8'd3, "R10");
    // R10 non-leap February and a 30-day month
    set_time(8'd99, 8'd23, 8'd59, 8'd59, 8'd2, 8'd28, 8'd5, 8'd1);
    cyc(1, 0, 0, 0); rd_chk(5'd5, 8'd1, "R10"); rd_chk(5'd4, 8'd3, "R10");
    set_time(8'd99, 8'd23, 8'd59, 8'd59, 8'd4, 8'd30, 8'd5, 8'd1);
    cyc(1, 0, 0, 0); rd_chk(5'd5, 8'd1, "R10"); rd_chk(5'd4, 8'd5, "R10");
    // R11 year wrap
    set_time(8'd99, 8'd23, 8'd59, 8'd59, 8'd12, 8'd31, 8'd255, 8'd2);
    cyc(1, 0, 0, 0); rd_chk(5'd6, 8'd0, "R11"); rd_chk(5'd7, 8'd3, "R11");

    // R9 12-hour mode
    cyc(0, 1, 5'd17, 8'h08);
    set_time(8'd99, 8'h0B, 8'd59, 8'd59, 8'd5, 8'd10, 8'd7, 8'd2);
    cyc(1, 0, 0, 0); rd_chk(5'd1, 8'h8C, "R9"); rd_chk(5'd5, 8'd10, "R9");
    cyc(0, 1, 5'd0, 8'd99); cyc(0, 1, 5'd3, 8'd59); cyc(0, 1, 5'd2, 8'd59);
    cyc(1, 0, 0, 0); rd_chk(5'd1, 8'h81, "R9");
    set_time(8'd99, 8'h8B, 8'd59, 8'd59, 8'd5, 8'd10, 8'd7, 8'd2);
    cyc(1, 0, 0, 0); rd_chk(5'd1, 8'h0C, "R9"); rd_chk(5'd5, 8'd11, "R9");
    chk_time("R9");

    // R12 write collides with a carrying tick
    set_time(8'd99, 8'h03, 8'd10, 8'd59, 8'd5, 8'd10, 8'd7, 8'd2);
    cyc(1, 1, 5'd3, 8'd33);
    rd_chk(5'd3, 8'd33, "R12"); rd_chk(5'd0, 8'd0, "R12"); rd_chk(5'd2, 8'd11, "R12");

    // random mix, R12 collisions included
    cyc(0, 1, 5'd17, 8'h0C);
    for (int it = 0; it < 600; it++) begin
      int sel;
      sel = int'($urandom % 20);
      if (sel < 12) cyc(1, 0, 0, 0);
      else if (sel < 16) begin
        int f; f = int'($urandom % 8);
        cyc(1'($urandom), 1, 5'(f), rand_field(f));
      end else if (sel < 17) cyc(1, 1, 5'(8 + $urandom % 8), 8'($urandom));
      else if (sel < 18) cyc(1, 1, 5'(18 + $urandom % 14), 8'($urandom));
      else cyc(0, 1, 5'd17, {4'h0, 1'($urandom % 4 != 0), 1'($urandom), 2'($urandom)});
      if (it % 25 == 24) begin chk_time("R12"); chk_ctrl("R5"); end
    end
    for (int i = 8; i < 16; i++) rd_chk(5'(i), cm[i-8], "R3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule